// File: doc/BRIEF.md
# Event Counter Bank with Scaled Counting and Overflow Interrupt

The block counts hardware events for software profiling. It holds a bank of wide counters, and each one watches one line of a wide event bus. A privileged master programs the unit through a small synchronous register port. Every register also appears at a second address that has the top address bit set. Unprivileged code can read these mirror addresses but cannot change anything through them.

Each counter has its own freeze bits, chosen by the processor's current privilege level or by software. A global word can stop every counter at once or turn the whole unit off. A counter can be slowed down by a prescaler with a limit of threshold shifted left by a 3-bit code. A counter whose top bit is set is in the overflow state. An interrupt request is raised when the per-counter, global and processor enables all agree. The unit can also stop itself the moment an armed counter overflows.

Top module: `perf_mon_unit`

## Requirements
- R1: After reset, every register reads zero and `irq` is low.
- R2: Register map, with bit 7 of `req_addr` clear for read/write access: global word at 0x00, counter i at 0x10+i, select word i at 0x20+i, scale word i at 0x30+i. A read request returns its data on `rsp_rdata` with `rsp_valid` high in the next cycle. The same address with bit 7 set reads the same value.
- R3: A write with bit 7 set changes no register, and `acc_err` is high in the next cycle. `acc_err` is never high otherwise.
- R4: The select word holds the event index in bits [6:0]. An enabled, unfrozen counter increments once for each clock in which its selected event line is high. Other event lines have no effect on it.
- R5: Global word bit 3 is the unit enable. While it is 0, no counter advances and `irq` stays low.
- R6: Global word bit 0 freezes all counters while it is set.
- R7: Select word bit 8 freezes the counter when `priv_mode`=0 (user), bit 9 freezes it when `priv_mode`=1 (supervisor), and bit 10 freezes it regardless of `priv_mode`.
- R8: The scale word holds the threshold in bits [5:0] and the code n in bits [10:8]. With a nonzero threshold, the counter increments on the (threshold*2^n + 1)-th qualified event, and the prescaler then restarts from zero. A threshold of zero counts every event.
- R9: A counter whose bit 31 is set is in overflow. It keeps counting and wraps from 0xFFFFFFFF to 0.
- R10: `irq` is high exactly when the unit is enabled, global bit 2 (overflow interrupt enable) is set, `ext_int_en` is high, and some counter is in overflow with its select word bit 11 (overflow signalling) set.
- R11: While global bit 1 is set, a counter with bit 11 set that steps from 0x7FFFFFFF into overflow sets global bit 0. Bit 0 stays set until software writes it.
- R12: A write to a counter takes precedence over a same-cycle increment and clears that counter's prescaler.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Register request strobe |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 8 | Register address, bit 7 selects the read-only mirror |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read data valid |
| rsp_rdata | output | 32 | Read data |
| acc_err | output | 1 | Write to a mirror address was rejected |
| event_in | input | 128 | Event lines |
| priv_mode | input | 1 | 1 = supervisor, 0 = user |
| ext_int_en | input | 1 | Processor external-interrupt enable |
| irq | output | 1 | Interrupt request |

## Verification
The hardest case to reach is the prescaler's memory across an unrelated software event. This is a counter that was left holding a partial prescale count and is then rewritten while its event line is high. The stimulus first leaves the scaled counter exactly at its limit. It then writes the counter with the event asserted in the same cycle. This sequence exposes both the write-over-increment priority and the prescaler clear. The stimulus also reaches the overflow boundary quickly by preloading counters with 0x7FFFFFFE, 0x7FFFFFFF and 0xFFFFFFFF rather than counting up to it.

// File: rtl/perf_mon_unit.sv
module perf_mon_unit #(
  parameter int NUM_CTR = 4,
  parameter int CTR_W   = 32,
  parameter int NUM_EVT = 128,
  parameter int THR_W   = 6,
  parameter int MUL_W   = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  input  logic               req_write,
  input  logic [7:0]         req_addr,
  input  logic [31:0]        req_wdata,
  output logic               rsp_valid,
  output logic [31:0]        rsp_rdata,
  output logic               acc_err,
  input  logic [NUM_EVT-1:0] event_in,
  input  logic               priv_mode,
  input  logic               ext_int_en,
  output logic               irq
);
  localparam int SEL_W = $clog2(NUM_EVT);
  localparam int IDX_W = (NUM_CTR > 1) ? $clog2(NUM_CTR) : 1;
  localparam int PRE_W = THR_W + (1 << MUL_W) - 1;
  localparam logic [CTR_W-1:0] TOP_POS = {1'b0, {(CTR_W-1){1'b1}}};

  logic [3:0]                     gctl;
  logic [NUM_CTR-1:0][CTR_W-1:0]  ctr;
  logic [NUM_CTR-1:0][11:0]       lsel;
  logic [NUM_CTR-1:0][10:0]       lscl;
  logic [NUM_CTR-1:0]             trig, ovf_sig;

  wire       wr_ok = req_valid & req_write & ~req_addr[7];
  wire [2:0] grp   = req_addr[6:4];
  wire [3:0] idx   = req_addr[3:0];
  wire       idx_ok = 32'(idx) < NUM_CTR;
  wire       wr_g  = wr_ok & (grp == 3'd0) & (idx == 4'd0);

  for (genvar i = 0; i < NUM_CTR; i++) begin : g_ctr
    logic [PRE_W-1:0] pre;
    wire  hit_idx = idx == 4'(i);
    wire  wr_c    = wr_ok & (grp == 3'd1) & hit_idx;
    wire  wr_s    = wr_ok & (grp == 3'd2) & hit_idx;
    wire  wr_k    = wr_ok & (grp == 3'd3) & hit_idx;
    wire [SEL_W-1:0] sel = lsel[i][SEL_W-1:0];
    wire [THR_W-1:0] thr = lscl[i][THR_W-1:0];
    wire [MUL_W-1:0] mul = lscl[i][8 +: MUL_W];
    wire [PRE_W-1:0] lim = PRE_W'(thr) << mul;
    wire  mode_frz = priv_mode ? lsel[i][9] : lsel[i][8];
    wire  run = gctl[3] & ~gctl[0] & ~lsel[i][10] & ~mode_frz;
    wire  hit = run & event_in[sel];
    wire  inc = hit & ((thr == '0) | (pre >= lim));

    assign trig[i]    = inc & ~wr_c & lsel[i][11] & (ctr[i] == TOP_POS);
    assign ovf_sig[i] = ctr[i][CTR_W-1] & lsel[i][11];

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        ctr[i]  <= '0;
        pre     <= '0;
        lsel[i] <= '0;
        lscl[i] <= '0;
      end else begin
        if (wr_c) begin
          ctr[i] <= req_wdata[CTR_W-1:0];
          pre    <= '0;
        end else if (inc) begin
          ctr[i] <= ctr[i] + 1'b1;
          pre    <= '0;
        end else if (hit) begin
          pre <= pre + 1'b1;
        end
        if (wr_s) lsel[i] <= req_wdata[11:0] & 12'hF7F;
        if (wr_k) lscl[i] <= req_wdata[10:0] & 11'h73F;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gctl <= '0;
    end else begin
      if (wr_g) gctl <= req_wdata[3:0];
      if (gctl[1] & (|trig)) gctl[0] <= 1'b1;
    end
  end

  logic [31:0] rd;
  wire  [IDX_W-1:0] ix = idx[IDX_W-1:0];
  always_comb begin
    rd = '0;
    case (grp)
      3'd0: if (idx == 4'd0) rd = 32'(gctl);
      3'd1: if (idx_ok) rd = 32'(ctr[ix]);
      3'd2: if (idx_ok) rd = 32'(lsel[ix]);
      3'd3: if (idx_ok) rd = 32'(lscl[ix]);
      default: rd = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
      acc_err   <= 1'b0;
    end else begin
      rsp_valid <= req_valid & ~req_write;
      rsp_rdata <= (req_valid & ~req_write) ? rd : '0;
      acc_err   <= req_valid & req_write & req_addr[7];
    end
  end

  assign irq = gctl[3] & gctl[2] & ext_int_en & (|ovf_sig);
endmodule

module perf_mon_unit_chk #(
  parameter int NUM_CTR = 4,
  parameter int CTR_W   = 32
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      req_valid,
  input logic                      req_write,
  input logic [7:0]                req_addr,
  input logic                      acc_err,
  input logic                      ext_int_en,
  input logic                      irq,
  input logic [3:0]                gctl,
  input logic [NUM_CTR-1:0][CTR_W-1:0] ctr
);
  wire any_wr = req_valid & req_write;

  p_irq_gate_r10: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (ext_int_en && gctl[2] && gctl[3]));

  p_mirror_err_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_write && req_addr[7]) |=> acc_err);

  p_err_cause_r3: assert property (@(posedge clk) disable iff (!rst_n)
    acc_err |-> $past(req_valid && req_write && req_addr[7]));

  p_freeze_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (gctl[0] && !any_wr) |=> $stable(ctr));

  p_disabled_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!gctl[3] && !any_wr) |=> $stable(ctr));

  p_freeze_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (gctl[0] && !any_wr) |=> gctl[0]);

  for (genvar i = 0; i < NUM_CTR; i++) begin : g_step
    p_single_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !any_wr |=> (ctr[i] == $past(ctr[i]) || ctr[i] == CTR_W'($past(ctr[i]) + 1'b1)));
  end
endmodule

bind perf_mon_unit perf_mon_unit_chk #(.NUM_CTR(NUM_CTR), .CTR_W(CTR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
  .req_addr(req_addr), .acc_err(acc_err), .ext_int_en(ext_int_en), .irq(irq),
  .gctl(gctl), .ctr(ctr));

// File: tb/tb_perf_mon_unit.sv
module tb_perf_mon_unit;
  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_write = 0;
  logic [7:0] req_addr = 0;
  logic [31:0] req_wdata = 0;
  logic rsp_valid, acc_err, irq;
  logic [31:0] rsp_rdata;
  logic [127:0] event_in = '0;
  logic priv_mode = 1, ext_int_en = 0;

  int checks = 0, errors = 0;
  logic [31:0] exp_q[$];
  string tag_q[$];

  always #5 clk = ~clk;

  perf_mon_unit dut (.*);

  task automatic tick(); @(posedge clk); #1; endtask

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    req_valid = 1; req_write = 1; req_addr = a; req_wdata = d;
    tick();
    req_valid = 0; req_write = 0;
  endtask

  task automatic rd(logic [7:0] a, logic [31:0] exp, string tag);
    exp_q.push_back(exp); tag_q.push_back(tag);
    req_valid = 1; req_write = 0; req_addr = a;
    tick();
    req_valid = 0;
  endtask

  task automatic pulse(int k, int n);
    event_in[k] = 1;
    repeat (n) tick();
    event_in[k] = 0;
  endtask

  always @(negedge clk) begin
    if (rst_n && rsp_valid) begin
      if (exp_q.size() == 0) begin
        checks++; errors++;
        $display("FAIL scoreboard: unexpected response actual=%h expected=none", rsp_rdata);
      end else begin
        chk(tag_q.pop_front(), rsp_rdata, exp_q.pop_front());
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) tick();
    rst_n = 1;
    tick();
    // R1
    rd(8'h00, 0, "R1 global");
    rd(8'h10, 0, "R1 ctr0");
    rd(8'h20, 0, "R1 sel0");
    rd(8'h33, 0, "R1 scl3");
    chk("R1 irq", 32'(irq), 0);
    // R2
    wr(8'h20, 32'h0000_0005);
    wr(8'h31, 32'h0000_0102);
    wr(8'h21, 32'h0000_000A);
    rd(8'h20, 32'h5, "R2 sel0");
    rd(8'hA0, 32'h5, "R2 mirror sel0");
    rd(8'hB1, 32'h102, "R2 mirror scl1");
    // R3
    wr(8'h90, 32'h1234_5678);
    chk("R3 acc_err", 32'(acc_err), 1);
    tick();
    chk("R3 acc_err clears", 32'(acc_err), 0);
    rd(8'h10, 0, "R3 ctr0 untouched");
    wr(8'h80, 32'hF);
    rd(8'h00, 0, "R3 global untouched");
    // R4
    wr(8'h00, 32'h8);
    pulse(5, 3);
    pulse(6, 4);
    rd(8'h10, 3, "R4 selected event counted");
    // R5
    wr(8'h00, 32'h0);
    pulse(5, 2);
    rd(8'h10, 3, "R5 disabled");
    // R6
    wr(8'h00, 32'h9);
    pulse(5, 2);
    rd(8'h10, 3, "R6 frozen");
    wr(8'h00, 32'h8);
    // R7
    wr(8'h20, 32'h205);
    priv_mode = 1; pulse(5, 2);
    rd(8'h10, 3, "R7 supervisor freeze");
    priv_mode = 0; pulse(5, 2);
    rd(8'h10, 5, "R7 user counts");
    wr(8'h20, 32'h105);
    pulse(5, 1);
    rd(8'h10, 5, "R7 user freeze");
    wr(8'h20, 32'h405);
    priv_mode = 1; pulse(5, 1);
    rd(8'h10, 5, "R7 software freeze");
    // R8: threshold 2, code 1 -> limit 4, count on 5th
    pulse(10, 4);
    rd(8'h11, 0, "R8 below limit");
    pulse(10, 1);
    rd(8'h11, 1, "R8 fifth event");
    pulse(10, 5);
    rd(8'h11, 2, "R8 prescaler restarts");
    pulse(10, 4);
    rd(8'h11, 2, "R8 partial");
    // R10 / R9
    wr(8'h22, 32'h814);
    wr(8'h12, 32'h7FFF_FFFE);
    wr(8'h00, 32'hC);
    pulse(20, 1);
    chk("R10 no overflow yet", 32'(irq), 0);
    pulse(20, 1);
    rd(8'h12, 32'h8000_0000, "R9 enters overflow");
    chk("R10 ext disabled", 32'(irq), 0);
    ext_int_en = 1; #1;
    chk("R10 all enables", 32'(irq), 1);
    wr(8'h22, 32'h014);
    chk("R10 signalling off", 32'(irq), 0);
    wr(8'h22, 32'h814);
    wr(8'h00, 32'h8);
    chk("R10 global off", 32'(irq), 0);
    wr(8'h12, 32'hFFFF_FFFF);
    pulse(20, 1);
    rd(8'h12, 0, "R9 wrap");
    // R11
    wr(8'h23, 32'h81E);
    wr(8'h13, 32'h7FFF_FFFF);
    wr(8'h00, 32'hA);
    pulse(30, 1);
    rd(8'h13, 32'h8000_0000, "R11 overflow");
    rd(8'h00, 32'hB, "R11 freeze set");
    pulse(30, 2);
    rd(8'h13, 32'h8000_0000, "R11 stays frozen");
    // R12: ctr1 prescaler holds 4 here
    wr(8'h00, 32'h8);
    event_in[10] = 1;
    wr(8'h11, 32'd100);
    event_in[10] = 0;
    rd(8'h11, 100, "R12 write wins");
    pulse(10, 4);
    rd(8'h11, 100, "R12 prescaler cleared");
    pulse(10, 1);
    rd(8'h11, 101, "R12 count resumes");
    repeat (3) tick();
    chk("scoreboard drained", 32'(exp_q.size()), 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule